// File: doc/BRIEF.md
# Triggered Multichannel Capture Reader

This block reads a burst of samples from a seven-channel motion sensor through a simple register read port. The channels are temperature, three acceleration axes and three angular-rate axes. A one-cycle trigger starts the burst. The block latches a 7-bit enable mask at that moment and then issues one register read for each enabled channel, in ascending channel index. Each completed read comes out as a 16-bit two's-complement sample tagged with its channel index. An end-of-burst marker closes the burst.

The very first read of a burst raises a capture flag on the read port. This tells the sensor to freeze all channels into one coherent snapshot. Every later read in the same burst leaves the flag low and fetches from the frozen bank. Channel `i` lives at register address 0x17 + `i`. If a read reports an error, the burst stops at once and the end marker carries an error bit. A trigger that arrives while a burst is running is dropped and counted.

Top module: `cap_reader`

## Requirements
- R1: After synchronous reset, `rd_req_o`, `smp_valid_o` and `eob_o` are low and `drop_cnt_o` is zero.
- R2: Reads go only to enabled channels, in ascending index order. Channel index 0 is temperature, 1 to 3 are acceleration X/Y/Z and 4 to 6 are angular rate X/Y/Z. The read address is 0x17 + index.
- R3: `rd_cap_o` is high on the first read request of a burst and low on every later request of that burst.
- R4: For each read acknowledged without error, exactly one sample is emitted in the cycle after the acknowledge. It carries `rd_data_i` unchanged and the channel index on `smp_chan_o`.
- R5: After the last sample of an error-free burst, `eob_o` pulses for one cycle with `eob_err_o` low, one cycle after that sample.
- R6: A read acknowledged with `rd_err_i` high produces no sample and ends the burst: no further request is made, and `eob_o` pulses with `eob_err_o` high.
- R7: A trigger with an all-zero enable mask makes no request and no sample. `eob_o` pulses with `eob_err_o` low two cycles after the trigger edge.
- R8: The enable mask is used only in the cycle the trigger is accepted; later changes have no effect on the burst. A trigger seen while a burst is in progress is ignored and increments `drop_cnt_o`, which saturates at its maximum.
- R9: A read request holds its address and capture flag unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Burst start pulse |
| chan_en_i | input | 7 | Channel enable mask, bit i enables channel i |
| rd_req_o | output | 1 | Read request valid |
| rd_addr_o | output | 8 | Register address of the request |
| rd_cap_o | output | 1 | Capture flag carried with the request |
| rd_ack_i | input | 1 | Read completed this cycle |
| rd_err_i | input | 1 | Read completed with an error (valid with ack) |
| rd_data_i | input | 16 | Read data (valid with ack) |
| smp_valid_o | output | 1 | Sample valid pulse |
| smp_chan_o | output | 3 | Channel index of the sample |
| smp_data_o | output | 16 | Signed sample value |
| eob_o | output | 1 | End-of-burst pulse |
| eob_err_o | output | 1 | Burst was abandoned on a read error |
| drop_cnt_o | output | 8 | Saturating count of ignored triggers |

## Verification
The burst is exercised with several masks:
- a full mask;
- single-channel masks at both ends of the index range;
- sparse alternating masks, which show whether disabled channels are really skipped and whether addresses follow the index order.

Read latencies from zero to three cycles separate a request that is held correctly from one that moves before its acknowledge. Errors are injected on the first, a middle and the last enabled channel, to confirm that abandonment leaves no stray sample or request. Further runs cover the remaining cases:
- the enable input is inverted right after each trigger, which catches a mask that is not latched;
- an empty mask;
- short and very long runs of triggers during a busy burst, which exercise both counting and saturation of drops.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int unsigned NUM_CH   = 7;
    localparam int unsigned SMP_W    = 16;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DROP_W   = 8;
    localparam logic [7:0]  CAP_BASE = 8'h17;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_FIN
    } seq_state_e;

    // one-hot bit for channel index within a mask of n bits
    function automatic logic [31:0] ch_bit(input int unsigned idx);
        ch_bit = 32'd1 << idx;
    endfunction

endpackage

// File: rtl/cap_pick.sv
module cap_pick #(
    parameter int unsigned N_CH = cap_pkg::NUM_CH,
    localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] mask_i,
    output logic            any_o,
    output logic [CH_W-1:0] idx_o
);
    // lowest set bit wins: prefix OR chain marks bits already claimed below
    logic [N_CH:0] below;
    logic [N_CH-1:0] hit;

    assign below[0] = 1'b0;
    for (genvar g = 0; g < N_CH; g++) begin : g_chain
        assign hit[g]     = mask_i[g] & ~below[g];
        assign below[g+1] = below[g] | mask_i[g];
    end

    assign any_o = below[N_CH];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (hit[i]) idx_o = CH_W'(i);
        end
    end

endmodule

// File: rtl/cap_drop_cnt.sv
module cap_drop_cnt #(
    parameter int unsigned CNT_W = cap_pkg::DROP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (hit_i && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    // R8: every dropped trigger below the ceiling advances the count by one
    p_drop_step_r8: assert property (@(posedge clk) disable iff (rst)
        (hit_i && (cnt_q != {CNT_W{1'b1}})) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R8: count holds at its ceiling
    p_drop_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == {CNT_W{1'b1}}));

endmodule

// File: rtl/cap_seq.sv
module cap_seq
    import cap_pkg::*;
#(
    parameter int unsigned N_CH  = cap_pkg::NUM_CH,
    parameter int unsigned DW    = cap_pkg::SMP_W,
    parameter int unsigned AW    = cap_pkg::ADDR_W,
    parameter logic [7:0]  BASE  = cap_pkg::CAP_BASE,
    localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_i,
    input  logic [N_CH-1:0] mask_i,
    output logic            busy_o,
    output logic            rd_req_o,
    output logic [AW-1:0]   rd_addr_o,
    output logic            rd_cap_o,
    input  logic            rd_ack_i,
    input  logic            rd_err_i,
    input  logic [DW-1:0]   rd_data_i,
    output logic            smp_valid_o,
    output logic [CH_W-1:0] smp_chan_o,
    output logic [DW-1:0]   smp_data_o,
    output logic            eob_o,
    output logic            eob_err_o
);
    seq_state_e      st_q;
    logic [N_CH-1:0] pend_q;
    logic            first_q;
    logic            err_q;
    logic            cur_any;
    logic [CH_W-1:0] cur_idx;
    logic [N_CH-1:0] rest;

    cap_pick #(.N_CH(N_CH)) u_pick (
        .mask_i (pend_q),
        .any_o  (cur_any),
        .idx_o  (cur_idx)
    );

    assign rest      = pend_q & ~N_CH'(ch_bit(32'(cur_idx)));
    assign busy_o    = (st_q != ST_IDLE);
    assign rd_req_o  = (st_q == ST_READ);
    assign rd_addr_o = AW'(BASE) + AW'(cur_idx);
    assign rd_cap_o  = rd_req_o & first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            pend_q      <= '0;
            first_q     <= 1'b0;
            err_q       <= 1'b0;
            smp_valid_o <= 1'b0;
            smp_chan_o  <= '0;
            smp_data_o  <= '0;
            eob_o       <= 1'b0;
            eob_err_o   <= 1'b0;
        end else begin
            smp_valid_o <= 1'b0;
            eob_o       <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (trig_i) begin
                        pend_q  <= mask_i;
                        first_q <= 1'b1;
                        err_q   <= 1'b0;
                        st_q    <= (|mask_i) ? ST_READ : ST_FIN;
                    end
                end
                ST_READ: begin
                    if (rd_ack_i) begin
                        first_q <= 1'b0;
                        if (rd_err_i) begin
                            err_q  <= 1'b1;
                            pend_q <= '0;
                            st_q   <= ST_FIN;
                        end else begin
                            smp_valid_o <= 1'b1;
                            smp_chan_o  <= cur_idx;
                            smp_data_o  <= rd_data_i;
                            pend_q      <= rest;
                            if (!(|rest)) st_q <= ST_FIN;
                        end
                    end
                end
                ST_FIN: begin
                    eob_o     <= 1'b1;
                    eob_err_o <= err_q;
                    st_q      <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: requests stay inside the captured bank window
    p_addr_win_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> ((rd_addr_o >= AW'(BASE)) && (rd_addr_o < AW'(BASE) + AW'(N_CH))));

    // R2: a request is only made while a channel is pending
    p_req_pending_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> cur_any);

    // R3: once a read completes, no later request of the burst carries the flag
    p_cap_first_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && rd_ack_i) |=> !rd_cap_o);

    // R4: a good acknowledge yields a sample with the delivered data
    p_smp_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && rd_ack_i && !rd_err_i) |=> (smp_valid_o && (smp_data_o == $past(rd_data_i))));

    // R5: samples and end markers never share a cycle
    p_out_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({smp_valid_o, eob_o}));

    // R6: an errored read emits nothing and stops requesting
    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && rd_ack_i && rd_err_i) |=> (!smp_valid_o && !rd_req_o));

    // R7: an empty-mask trigger makes no request
    p_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && trig_i && (mask_i == '0)) |=> !rd_req_o);

    // R9: an unanswered request is held unchanged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o) && $stable(rd_cap_o)));

endmodule

// File: rtl/cap_reader.sv
module cap_reader #(
    parameter int unsigned N_CH   = cap_pkg::NUM_CH,
    parameter int unsigned DW     = cap_pkg::SMP_W,
    parameter int unsigned AW     = cap_pkg::ADDR_W,
    parameter int unsigned DROP_W = cap_pkg::DROP_W,
    parameter logic [7:0]  BASE   = cap_pkg::CAP_BASE,
    localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [N_CH-1:0]   chan_en_i,
    output logic              rd_req_o,
    output logic [AW-1:0]     rd_addr_o,
    output logic              rd_cap_o,
    input  logic              rd_ack_i,
    input  logic              rd_err_i,
    input  logic [DW-1:0]     rd_data_i,
    output logic              smp_valid_o,
    output logic [CH_W-1:0]   smp_chan_o,
    output logic [DW-1:0]     smp_data_o,
    output logic              eob_o,
    output logic              eob_err_o,
    output logic [DROP_W-1:0] drop_cnt_o
);
    logic busy;

    cap_seq #(
        .N_CH (N_CH),
        .DW   (DW),
        .AW   (AW),
        .BASE (BASE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig_i),
        .mask_i      (chan_en_i),
        .busy_o      (busy),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .rd_cap_o    (rd_cap_o),
        .rd_ack_i    (rd_ack_i),
        .rd_err_i    (rd_err_i),
        .rd_data_i   (rd_data_i),
        .smp_valid_o (smp_valid_o),
        .smp_chan_o  (smp_chan_o),
        .smp_data_o  (smp_data_o),
        .eob_o       (eob_o),
        .eob_err_o   (eob_err_o)
    );

    cap_drop_cnt #(.CNT_W(DROP_W)) u_drop (
        .clk   (clk),
        .rst   (rst),
        .hit_i (trig_i & busy),
        .cnt_o (drop_cnt_o)
    );

    // R1: outputs are quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!rd_req_o && !smp_valid_o && !eob_o && (drop_cnt_o == '0)));

endmodule

// File: tb/test_cap_reader.sv
module test_cap_reader;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 7;

    // vector fields: mask[19:13] err_ch[12:10] (7 = none) lat[9:8] seed[7:0]
    localparam logic [19:0] VECS [8] = '{
        {7'h7F, 3'd7, 2'd0, 8'h11},
        {7'h01, 3'd7, 2'd1, 8'h22},
        {7'h40, 3'd7, 2'd2, 8'h33},
        {7'h2A, 3'd7, 2'd0, 8'h44},
        {7'h55, 3'd7, 2'd3, 8'h85},
        {7'h7F, 3'd3, 2'd1, 8'h96},
        {7'h0E, 3'd1, 2'd0, 8'hA7},
        {7'h70, 3'd6, 2'd2, 8'hC8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [6:0]  chan_en = '0;
    logic        rd_req, rd_cap, rd_ack = 1'b0, rd_err = 1'b0;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data = '0;
    logic        smp_valid, eob, eob_err;
    logic [2:0]  smp_chan;
    logic [15:0] smp_data;
    logic [7:0]  drop_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int exp_drop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_reader i_cap_reader (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig),
        .chan_en_i   (chan_en),
        .rd_req_o    (rd_req),
        .rd_addr_o   (rd_addr),
        .rd_cap_o    (rd_cap),
        .rd_ack_i    (rd_ack),
        .rd_err_i    (rd_err),
        .rd_data_i   (rd_data),
        .smp_valid_o (smp_valid),
        .smp_chan_o  (smp_chan),
        .smp_data_o  (smp_data),
        .eob_o       (eob),
        .eob_err_o   (eob_err),
        .drop_cnt_o  (drop_cnt)
    );

    function automatic logic [15:0] pat(input int ch, input logic [7:0] seed);
        pat = {seed, 5'b0, 3'(ch)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_burst(input logic [6:0] mask, input int err_ch, input int lat,
                             input logic [7:0] seed, input int drop_n,
                             input logic [6:0] mask_late);
        int  lst[7];
        int  n_en, n_req_exp, n_smp_exp, cyc, nreq, nsmp, wait_c, last_smp;
        bit  err_exp, done;
        n_en = 0; err_exp = 0; n_req_exp = 0; n_smp_exp = 0;
        for (int i = 0; i < NCH; i++) if (mask[i]) begin lst[n_en] = i; n_en++; end
        n_req_exp = n_en; n_smp_exp = n_en;
        for (int k = 0; k < n_en; k++) if (!err_exp && lst[k] == err_ch) begin
            err_exp = 1; n_req_exp = k + 1; n_smp_exp = k;
        end
        @(negedge clk);
        trig = 1'b1; chan_en = mask;
        cyc = 0; nreq = 0; nsmp = 0; wait_c = 0; last_smp = -10; done = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            trig = (cyc <= drop_n);
            chan_en = mask_late;
            rd_ack = 1'b0; rd_err = 1'b0;
            if (smp_valid) begin
                if (nsmp < n_smp_exp) begin
                    check(smp_chan == 3'(lst[nsmp]), "R4 sample channel", smp_chan, lst[nsmp]);
                    check(smp_data == pat(lst[nsmp], seed), "R4 sample data",
                          smp_data, pat(lst[nsmp], seed));
                end else begin
                    check(0, "R6 unexpected sample", nsmp + 1, n_smp_exp);
                end
                nsmp++; last_smp = cyc;
            end
            if (eob) begin
                check(eob_err == err_exp, err_exp ? "R6 end error flag" : "R5 end error flag",
                      eob_err, err_exp);
                check(nsmp == n_smp_exp, "R4 sample count", nsmp, n_smp_exp);
                check(nreq == n_req_exp, "R2 request count", nreq, n_req_exp);
                if (n_en == 0) check(cyc == 2, "R7 empty burst end timing", cyc, 2);
                else if (!err_exp) check(last_smp == cyc - 1, "R5 end follows last sample",
                                         last_smp, cyc - 1);
                done = 1;
            end
            if (rd_req && !done) begin
                if (nreq >= n_req_exp) begin
                    check(0, "R6 extra request", nreq + 1, n_req_exp);
                    rd_ack = 1'b1;
                end else begin
                    check(rd_addr == 8'(8'h17 + lst[nreq]), "R2 R9 request address",
                          rd_addr, 8'h17 + lst[nreq]);
                    check(rd_cap == (nreq == 0), "R3 capture flag", rd_cap, nreq == 0);
                    if (wait_c == lat) begin
                        rd_ack  = 1'b1;
                        rd_data = pat(lst[nreq], seed);
                        rd_err  = (lst[nreq] == err_ch);
                        nreq++;
                        wait_c = 0;
                    end else begin
                        wait_c++;
                    end
                end
            end
        end
        trig = 1'b0; rd_ack = 1'b0; rd_err = 1'b0;
        check(done, "R5 end of burst seen", done, 1);
        exp_drop = (exp_drop + drop_n > 255) ? 255 : exp_drop + drop_n;
        check(drop_cnt == 8'(exp_drop), "R8 drop count", drop_cnt, exp_drop);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!rd_req, "R1 request idle", rd_req, 0);
        check(!smp_valid && !eob, "R1 outputs idle", {smp_valid, eob}, 0);
        check(drop_cnt == 0, "R1 drop count", drop_cnt, 0);

        // table walk; enable input inverted after trigger checks R8 latching
        for (int v = 0; v < 8; v++) begin
            run_burst(VECS[v][19:13], int'(VECS[v][12:10]), int'(VECS[v][9:8]),
                      VECS[v][7:0], 0, ~VECS[v][19:13]);
        end

        // R7 empty mask
        run_burst(7'h00, 7, 0, 8'h5A, 0, 7'h7F);
        // R8 a few triggers during a burst are dropped
        run_burst(7'h13, 7, 1, 8'h3C, 3, 7'h00);
        // R8 saturation of the drop count
        run_burst(7'h7F, 7, 40, 8'hE1, 270, 7'h7F);
        // R8 count stays saturated
        run_burst(7'h08, 7, 0, 8'h77, 2, 7'h08);

        // R1 reset clears the count
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(drop_cnt == 0, "R1 drop count after reset", drop_cnt, 0);
        check(!rd_req && !eob, "R1 idle after reset", {rd_req, eob}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule